// File: doc/BRIEF.md
# Multiprocessor Priority Interrupt Controller

This block gathers 32 level-sensitive system interrupt sources and a private pending word for each of up to four processors, and hands each processor a single prioritised request. System sources pass through a disable mask. Each surviving source is converted to a 4-bit priority through a table fixed at build time, and the highest level wins. The winning system level goes to one processor only, chosen by a programmable target register. Each processor's private word holds software levels and locally routed interrupts. That word is resolved on its own and combined with the system level when the processor is the target.

A processor sees a request flag and an 8-bit code that carries the external-interrupt trap class in the upper nibble and the level in the lower nibble. The request is raised only while the processor has nothing outstanding. It stays up until the processor acknowledges it. A request raised toward a halted processor comes with a one-cycle wake pulse. Software uses a small write port to set and clear private pending bits, to set and clear disable bits, and to pick the target. A local-event port sets or clears a private bit from a source's table level. It drives a system pending bit instead when the processor index is all ones.

Top module: `mpic_top`

## Requirements
- R1: After reset every request, code and wake output is 0, the target register is 0 and no source is disabled.
- R2: A write with select 0 (private set) to processor `wr_cpu` ORs only data bits 31..17 into that processor's pending word; data bits 16..0 have no effect.
- R3: A processor's private level is the larger of (index of the highest set pending bit among 31..17, minus 16) and (index of the highest set pending bit among 15..1).
- R4: The system level is the maximum table level over the bits of `(src_in | system pending) & ~disable`; the default table gives source i the level i mod 16, so level 0 sources never interrupt.
- R5: The system level reaches only the processor named by the target register (select 4, data bits [1:0]); when that processor slot is absent nothing is delivered.
- R6: A processor's candidate level is the maximum of its private level and, if it is the target, the system level.
- R7: When a present processor has no outstanding request and a nonzero candidate level, the next clock edge raises `irq_req` with code `{4'h1, level}`; while the request stays outstanding, the request and code hold stable and further pending changes raise nothing new.
- R8: Asserting the processor's acknowledge while its request is up drops the request on the next edge; a still-pending level is raised again one edge later.
- R9: `irq_wake` pulses for exactly the cycle in which a request rises, and only if that processor's halted input was high on the raising edge.
- R10: A local event with a processor index below the processor count sets (on) or clears (off) pending bit `L` of that processor, where L is the table level of `loc_src`; a source with table level 0 changes nothing.
- R11: A local event whose processor index is all ones sets or clears system pending bit `loc_src` instead.
- R12: Select 1 clears private pending bits of `wr_cpu` (bits set in data); select 2 sets and select 3 clears disable bits.
- R13: A processor slot marked absent never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 private set, 1 private clear, 2 disable set, 3 disable clear, 4 target) |
| wr_cpu | input | 2 | Processor addressed by private set/clear |
| wr_data | input | 32 | Write data |
| src_in | input | 32 | System interrupt source levels |
| loc_valid | input | 1 | Local event strobe |
| loc_cpu | input | 3 | Local event processor index (all ones = system) |
| loc_src | input | 5 | Local event source number |
| loc_on | input | 1 | Local event level (1 set, 0 clear) |
| cpu_halted | input | 4 | Per-processor halted status |
| cpu_ack | input | 4 | Per-processor acknowledge |
| irq_req | output | 4 | Per-processor outstanding request |
| irq_code | output | 32 | Per-processor 8-bit code, processor c at bits [8c+7:8c] |
| irq_wake | output | 4 | Per-processor one-cycle wake pulse |

## Verification
The assertions take for granted that a processor acknowledges only its own outstanding request and that the halted status is steady around the raising edge. They also take for granted that the write port and local-event port carry at most one transaction per cycle. The stimulus acknowledges a processor only after it has seen the request rise. It clears the causing pending state before acknowledging unless a re-raise is the point of the case, and it drives every strobe for exactly one clock, so no two events collide.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam int SRC_N     = 32;
  localparam int DATA_W    = 32;
  localparam int LVL_W     = 4;
  localparam int CODE_W    = 8;
  localparam int SRC_IDX_W = $clog2(SRC_N);
  localparam int PEND_W    = (1 << LVL_W) - 1;   // private bits per half
  localparam int SOFT_LSB  = DATA_W - PEND_W;    // 17
  localparam int TBL_W     = SRC_N * LVL_W;
  localparam logic [3:0] TRAP_EXT = 4'h1;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [2:0] {
    SEL_PRIV_SET = 3'd0,
    SEL_PRIV_CLR = 3'd1,
    SEL_DIS_SET  = 3'd2,
    SEL_DIS_CLR  = 3'd3,
    SEL_TARGET   = 3'd4
  } reg_sel_e;

  function automatic logic [TBL_W-1:0] default_table();
    logic [TBL_W-1:0] t;
    for (int i = 0; i < SRC_N; i++) t[i*LVL_W +: LVL_W] = LVL_W'(i % 16);
    return t;
  endfunction

  function automatic lvl_t tbl_level(input logic [TBL_W-1:0] t,
                                     input logic [SRC_IDX_W-1:0] idx);
    return t[int'(idx)*LVL_W +: LVL_W];
  endfunction

  function automatic lvl_t lvl_max(input lvl_t a, input lvl_t b);
    return (a > b) ? a : b;
  endfunction

  // Highest set bit position (1-based) of a private half word.
  function automatic lvl_t top_bit(input logic [PEND_W-1:0] v);
    lvl_t r = '0;
    for (int j = 0; j < PEND_W; j++) if (v[j]) r = LVL_W'(j + 1);
    return r;
  endfunction

  function automatic lvl_t sys_level(input logic [SRC_N-1:0] active,
                                     input logic [TBL_W-1:0] t);
    lvl_t r = '0;
    for (int i = 0; i < SRC_N; i++)
      if (active[i]) r = lvl_max(r, t[i*LVL_W +: LVL_W]);
    return r;
  endfunction
endpackage

// File: rtl/mpic_sys_resolve.sv
module mpic_sys_resolve
  import mpic_pkg::*;
#(
  parameter logic [TBL_W-1:0] LVL_TABLE = default_table()
) (
  input  logic [SRC_N-1:0] src_in,
  input  logic [SRC_N-1:0] sys_pend,
  input  logic [SRC_N-1:0] disable_mask,
  output logic [SRC_N-1:0] active,
  output lvl_t             level
);
  assign active = (src_in | sys_pend) & ~disable_mask;
  assign level  = sys_level(active, LVL_TABLE);
endmodule

// File: rtl/mpic_cpu_slot.sv
module mpic_cpu_slot
  import mpic_pkg::*;
#(
  parameter bit PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_set,
  input  logic              priv_clr,
  input  logic [PEND_W-1:0] wsoft,
  input  logic [PEND_W-1:0] wloc,
  input  logic              loc_en,
  input  logic              loc_on,
  input  lvl_t              loc_lvl,
  input  lvl_t              sys_lvl,
  input  logic              ack,
  input  logic              halted,
  output logic              req,
  output logic [CODE_W-1:0] code,
  output logic              wake,
  output lvl_t              priv,
  output lvl_t              cand
);
  logic [PEND_W-1:0] soft_q, loc_q, soft_n, loc_n;
  logic              raise;

  always_comb begin
    soft_n = soft_q;
    loc_n  = loc_q;
    if (priv_set) soft_n = soft_n | wsoft;
    if (priv_clr) begin
      soft_n = soft_n & ~wsoft;
      loc_n  = loc_n & ~wloc;
    end
    if (loc_en && loc_lvl != '0) loc_n[int'(loc_lvl) - 1] = loc_on;
  end

  assign priv  = lvl_max(top_bit(soft_q), top_bit(loc_q));
  assign cand  = lvl_max(priv, sys_lvl);
  assign raise = PRESENT && !req && (cand != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_q <= '0;
      loc_q  <= '0;
      req    <= 1'b0;
      code   <= '0;
      wake   <= 1'b0;
    end else begin
      soft_q <= soft_n;
      loc_q  <= loc_n;
      wake   <= raise && halted;
      if (req && ack) begin
        req <= 1'b0;
      end else if (raise) begin
        req  <= 1'b1;
        code <= {TRAP_EXT, cand};
      end
    end
  end
endmodule

// File: rtl/mpic_top.sv
module mpic_top
  import mpic_pkg::*;
#(
  parameter int NCPU = 4,
  parameter logic [NCPU-1:0] CPU_PRESENT = '1,
  parameter logic [TBL_W-1:0] LVL_TABLE = default_table(),
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_sel,
  input  logic [CPU_W-1:0]       wr_cpu,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [SRC_N-1:0]       src_in,
  input  logic                   loc_valid,
  input  logic [CPU_W:0]         loc_cpu,
  input  logic [SRC_IDX_W-1:0]   loc_src,
  input  logic                   loc_on,
  input  logic [NCPU-1:0]        cpu_halted,
  input  logic [NCPU-1:0]        cpu_ack,
  output logic [NCPU-1:0]        irq_req,
  output logic [NCPU*CODE_W-1:0] irq_code,
  output logic [NCPU-1:0]        irq_wake
);
  logic [SRC_N-1:0]      dis_q, sys_q, active;
  logic [CPU_W-1:0]      tgt_q;
  lvl_t                  sys_lvl, loc_lvl;
  logic                  loc_global;
  logic [NCPU*LVL_W-1:0] priv_bus, cand_bus;

  assign loc_global = loc_valid && (&loc_cpu);
  assign loc_lvl    = tbl_level(LVL_TABLE, loc_src);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis_q <= '0;
      sys_q <= '0;
      tgt_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_DIS_SET: dis_q <= dis_q | wr_data;
          SEL_DIS_CLR: dis_q <= dis_q & ~wr_data;
          SEL_TARGET:  tgt_q <= wr_data[CPU_W-1:0];
          default: ;
        endcase
      end
      if (loc_global) sys_q[loc_src] <= loc_on;
    end
  end

  mpic_sys_resolve #(.LVL_TABLE(LVL_TABLE)) u_sys (
    .src_in      (src_in),
    .sys_pend    (sys_q),
    .disable_mask(dis_q),
    .active      (active),
    .level       (sys_lvl)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic hit_wr, hit_loc;
    lvl_t slot_sys;
    assign hit_wr   = wr_en && (wr_cpu == CPU_W'(c));
    assign hit_loc  = loc_valid && (loc_cpu == (CPU_W+1)'(c));
    assign slot_sys = (tgt_q == CPU_W'(c)) ? sys_lvl : '0;

    mpic_cpu_slot #(.PRESENT(CPU_PRESENT[c])) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .priv_set(hit_wr && (wr_sel == SEL_PRIV_SET)),
      .priv_clr(hit_wr && (wr_sel == SEL_PRIV_CLR)),
      .wsoft   (wr_data[DATA_W-1:SOFT_LSB]),
      .wloc    (wr_data[PEND_W:1]),
      .loc_en  (hit_loc),
      .loc_on  (loc_on),
      .loc_lvl (loc_lvl),
      .sys_lvl (slot_sys),
      .ack     (cpu_ack[c]),
      .halted  (cpu_halted[c]),
      .req     (irq_req[c]),
      .code    (irq_code[c*CODE_W +: CODE_W]),
      .wake    (irq_wake[c]),
      .priv    (priv_bus[c*LVL_W +: LVL_W]),
      .cand    (cand_bus[c*LVL_W +: LVL_W])
    );
  end
endmodule

// File: rtl/mpic_checker.sv
module mpic_checker
  import mpic_pkg::*;
#(
  parameter int NCPU = 4,
  parameter logic [NCPU-1:0] CPU_PRESENT = '1,
  parameter int CPU_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCPU-1:0]        irq_req,
  input logic [NCPU*CODE_W-1:0] irq_code,
  input logic [NCPU-1:0]        irq_wake,
  input logic [NCPU-1:0]        cpu_ack,
  input logic [NCPU-1:0]        cpu_halted,
  input logic [CPU_W-1:0]       tgt_q,
  input logic [NCPU*LVL_W-1:0]  priv_bus,
  input logic [NCPU*LVL_W-1:0]  cand_bus
);
  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    a_r7_code_form: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] |-> (irq_code[c*CODE_W+4 +: 4] == TRAP_EXT) && (irq_code[c*CODE_W +: 4] != 4'd0));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[c] && !cpu_ack[c]) |=> (irq_req[c] && $stable(irq_code[c*CODE_W +: CODE_W])));

    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[c] && cpu_ack[c]) |=> !irq_req[c]);

    a_r9_wake_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wake[c] |-> ($rose(irq_req[c]) && $past(cpu_halted[c])));

    a_r5_nontarget_private: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_req[c]) && $past(tgt_q) != CPU_W'(c))
        |-> irq_code[c*CODE_W +: 4] == $past(priv_bus[c*LVL_W +: LVL_W]));

    if (CPU_PRESENT[c]) begin : g_present
      a_r7_raise_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req[c] && cand_bus[c*LVL_W +: LVL_W] != '0) |=> irq_req[c]);
    end else begin : g_absent
      a_r13_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req[c]);
    end
  end
endmodule

bind mpic_top mpic_checker #(.NCPU(NCPU), .CPU_PRESENT(CPU_PRESENT), .CPU_W(CPU_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .irq_code  (irq_code),
  .irq_wake  (irq_wake),
  .cpu_ack   (cpu_ack),
  .cpu_halted(cpu_halted),
  .tgt_q     (tgt_q),
  .priv_bus  (priv_bus),
  .cand_bus  (cand_bus)
);

// File: tb/mpic_top_test.sv
module mpic_top_test;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [1:0]  wr_cpu = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] src_in = '0;
  logic        loc_valid = 1'b0;
  logic [2:0]  loc_cpu = '0;
  logic [4:0]  loc_src = '0;
  logic        loc_on = 1'b0;
  logic [3:0]  cpu_halted = '0;
  logic [3:0]  cpu_ack = '0;
  logic [3:0]  irq_req;
  logic [31:0] irq_code;
  logic [3:0]  irq_wake;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    int         cpu;
    logic [7:0] code;
    logic       wake;
    string      tag;
  } item_t;
  item_t exp_q[$];
  logic [3:0] prev_req = '0;

  always #10 clk = ~clk;

  mpic_top #(.NCPU(NCPU), .CPU_PRESENT(4'b0111)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_cpu(wr_cpu),
    .wr_data(wr_data), .src_in(src_in), .loc_valid(loc_valid), .loc_cpu(loc_cpu),
    .loc_src(loc_src), .loc_on(loc_on), .cpu_halted(cpu_halted), .cpu_ack(cpu_ack),
    .irq_req(irq_req), .irq_code(irq_code), .irq_wake(irq_wake)
  );

  // Bench model of the table and the private level rule.
  function automatic int src_lvl(int s);
    return s % 16;
  endfunction
  function automatic int soft_lvl(logic [31:0] d);
    for (int j = 31; j >= 17; j--) if (d[j]) return j - 16;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_irq(int cpu, int lvl, logic wk, string tag);
    item_t it;
    it.cpu = cpu; it.code = 8'h10 + 8'(lvl); it.wake = wk; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: each rising request is compared with the head of the queue.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCPU; c++) begin
        if (irq_req[c] && !prev_req[c]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected raise", c, -1);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            chk(it.cpu == c, it.tag, c, it.cpu);
            chk(irq_code[c*8 +: 8] == it.code, it.tag, irq_code[c*8 +: 8], it.code);
            chk(irq_wake[c] == it.wake, {it.tag, " R9 wake"}, irq_wake[c], it.wake);
          end
        end
      end
    end
    prev_req = irq_req;
  end

  task automatic write_reg(int sel, int cpu, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = 3'(sel); wr_cpu = 2'(cpu); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic local_ev(int cpu, int src, bit on);
    @(posedge clk); #1;
    loc_valid = 1'b1; loc_cpu = 3'(cpu); loc_src = 5'(src); loc_on = on;
    @(posedge clk); #1;
    loc_valid = 1'b0;
  endtask

  task automatic set_src(logic [31:0] v);
    @(posedge clk); #1;
    src_in = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ack_cpu(int c, string tag);
    @(posedge clk); #1;
    cpu_ack[c] = 1'b1;
    @(posedge clk); #1;
    cpu_ack[c] = 1'b0;
    chk(irq_req[c] == 1'b0, tag, irq_req[c], 0);
  endtask

  task automatic settle(string tag);
    idle(4);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    chk(irq_req == 4'h0, "R1 req", irq_req, 0);
    chk(irq_code == 32'h0, "R1 code", irq_code, 0);
    chk(irq_wake == 4'h0, "R1 wake", irq_wake, 0);
    rst_n = 1'b1;
    idle(2);
    chk(irq_req == 4'h0, "R1 idle after reset", irq_req, 0);

    // R2/R3: all bits written, only 31..17 kept -> level 15
    expect_irq(1, soft_lvl(32'hFFFF_FFFF), 1'b0, "R2 soft set all");
    write_reg(0, 1, 32'hFFFF_FFFF);
    idle(3);
    chk(irq_req[1] == 1'b1, "R7 req up", irq_req[1], 1);
    write_reg(1, 1, 32'hFFFF_FFFF);          // R12 private clear
    ack_cpu(1, "R8 ack drop");
    settle("R12 cleared no reraise");

    // R2: low bits only -> nothing
    write_reg(0, 0, 32'h0001_FFFF);
    idle(4);
    chk(irq_req == 4'h0, "R2 low bits ignored", irq_req, 0);

    // R3/R7/R8: hold while busy, re-raise at higher level after ack
    expect_irq(0, 4, 1'b0, "R3 bit20 level4");
    write_reg(0, 0, 32'h0010_0000);
    idle(3);
    write_reg(0, 0, 32'h0200_0000);
    idle(3);
    chk(irq_code[7:0] == 8'h14, "R7 code held while busy", irq_code[7:0], 8'h14);
    expect_irq(0, 9, 1'b0, "R8 reraise level9");
    ack_cpu(0, "R8 ack before reraise");
    idle(3);
    write_reg(1, 0, 32'hFFFF_FFFF);
    ack_cpu(0, "R8 ack final");
    settle("R8 queue");

    // R1/R4/R5: source 5 -> level 5 to default target 0
    expect_irq(0, src_lvl(5), 1'b0, "R4 source5 target0");
    set_src(32'h0000_0020);
    idle(3);
    set_src(32'h0);
    ack_cpu(0, "R4 ack");
    settle("R4 queue");

    // R12/R4: disabled source 7 ignored, source 3 still delivered
    write_reg(2, 0, 32'h0000_0080);
    set_src(32'h0000_0080);
    idle(4);
    chk(irq_req == 4'h0, "R12 disabled source", irq_req, 0);
    expect_irq(0, src_lvl(3), 1'b0, "R4 source3 with 7 masked");
    set_src(32'h0000_0088);
    idle(3);
    set_src(32'h0);
    ack_cpu(0, "R4 ack2");
    write_reg(3, 0, 32'h0000_0080);
    settle("R12 queue");

    // R4: maximum of sources 2, 13, 18
    expect_irq(0, 13, 1'b0, "R4 max of three");
    set_src(32'h0004_2004);
    idle(3);
    set_src(32'h0);
    ack_cpu(0, "R4 ack3");
    settle("R4 max queue");

    // R4: level-0 source 16
    set_src(32'h0001_0000);
    idle(4);
    chk(irq_req == 4'h0, "R4 level0 source", irq_req, 0);
    set_src(32'h0);

    // R5: target 2
    write_reg(4, 0, 32'h2);
    expect_irq(2, src_lvl(9), 1'b0, "R5 target2");
    set_src(32'h0000_0200);
    idle(3);
    chk(irq_req[0] == 1'b0, "R5 non-target quiet", irq_req[0], 0);
    set_src(32'h0);
    ack_cpu(2, "R5 ack");
    settle("R5 queue");

    // R5/R13: absent target 3
    write_reg(4, 0, 32'h3);
    set_src(32'h0000_0200);
    idle(4);
    chk(irq_req == 4'h0, "R5 absent target", irq_req, 0);
    set_src(32'h0);
    write_reg(4, 0, 32'h0);
    idle(2);

    // R10: local event on CPU 1, source 6
    expect_irq(1, src_lvl(6), 1'b0, "R10 local set");
    local_ev(1, 6, 1'b1);
    idle(3);
    local_ev(1, 6, 1'b0);
    ack_cpu(1, "R10 ack");
    settle("R10 local clear");
    // R10: level-0 source ignored
    local_ev(2, 16, 1'b1);
    idle(4);
    chk(irq_req == 4'h0, "R10 level0 local ignored", irq_req, 0);

    // R11: all-ones index -> system bit 11 -> target 0
    expect_irq(0, src_lvl(11), 1'b0, "R11 global local");
    local_ev(7, 11, 1'b1);
    idle(3);
    local_ev(7, 11, 1'b0);
    ack_cpu(0, "R11 ack");
    settle("R11 queue");

    // R6: private 3 combined with system 10 on the target
    expect_irq(0, 3, 1'b0, "R6 private first");
    write_reg(0, 0, 32'h0008_0000);
    idle(3);
    set_src(32'h0000_0400);
    expect_irq(0, 10, 1'b0, "R6 max of private and system");
    ack_cpu(0, "R6 ack");
    idle(3);
    set_src(32'h0);
    write_reg(1, 0, 32'hFFFF_FFFF);
    ack_cpu(0, "R6 ack final");
    settle("R6 queue");

    // R9: halted CPU 2 gets a wake pulse
    cpu_halted[2] = 1'b1;
    expect_irq(2, 7, 1'b1, "R9 wake with raise");
    write_reg(0, 2, 32'h0080_0000);
    idle(2);
    chk(irq_wake[2] == 1'b0, "R9 wake one cycle", irq_wake[2], 0);
    write_reg(1, 2, 32'hFFFF_FFFF);
    ack_cpu(2, "R9 ack");
    cpu_halted[2] = 1'b0;
    settle("R9 queue");

    // R13: absent CPU 3 private set
    write_reg(0, 3, 32'hFFFE_0000);
    idle(4);
    chk(irq_req[3] == 1'b0, "R13 absent cpu", irq_req[3], 0);

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule